// File: doc/BRIEF.md
# Interval Timer with Level and Periodic Interrupt

This block is an 8-bit presettable binary down-counter that decrements on one of four selectable tick strobes: a fast tick, a 64 Hz tick, a one-second tick and a one-minute tick. When the count steps from one to zero the block raises a sticky event flag and drives an open-drain interrupt enable. The interrupt works in one of two modes. In level mode the counter halts at zero and the interrupt follows the flag. In periodic mode the counter reloads from the preset and keeps running, and the interrupt is a short pulse that releases on its own.

Software reaches the block through a small write port with three addresses: the preset value, a control word (run, mode, source) and a status word (flag clear, interrupt enable). The live count, the flag, the run bit and the interrupt enable are available as outputs. The tick strobes and the 64 Hz phase level are produced outside the block, and every tick of the slower sources arrives on a rising edge of that phase.

Top module: `ivt_core`

## Requirements
- R1: Control bits [1:0] pick the decrement tick: 00 = tick_4k_i, 01 = tick_64_i, 10 = tick_1s_i, 11 = tick_1m_i. The other strobes have no effect on the count.
- R2: A write to address 0 loads wr_data_i into the preset and into the live count on that same clock edge. The preset keeps its value until it is written again.
- R3: Writing 1 to control bit 3 (run) at address 1 starts nothing at once. The first selected tick after the write only arms the counter, and each selected tick after that decrements it by one.
- R4: Writing 0 to the run bit lets at most one more selected tick decrement the count. After that the count stays frozen, and that last decrement may still produce a zero event.
- R5: In level mode (control bit 2 = 0), a decrement from 1 to 0 sets the flag, clears the run bit and leaves the count at 0.
- R6: If counting was started (run written from 0 to 1) while the flag was already 1, a level-mode zero event leaves the run bit at 1, and the count stays at 0.
- R7: In periodic mode (control bit 2 = 1), a decrement from 1 to 0 sets the flag and loads the preset into the count on the same edge, so events repeat every preset ticks.
- R8: A periodic interrupt pulse lasts RET_FAST_CYC clock cycles when source 00 is selected. With any other source it lasts until the next falling edge of phase_64_i.
- R9: The flag stays set until a write to address 2 with bit 1 = 0. Writing bit 1 = 1 has no effect, and a clear is ignored during the GUARD_CYC cycles after the flag is set.
- R10: A count of 0 with run set never decrements and never produces an event, in either mode.
- R11: irq_pull_o is 1 only while the interrupt enable (address 2 bit 0) is 1 and either the flag (level mode) or the periodic pulse (periodic mode) is active. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_4k_i | input | 1 | Fast tick strobe, one cycle wide |
| tick_64_i | input | 1 | 64 Hz tick strobe |
| tick_1s_i | input | 1 | One-second tick strobe |
| tick_1m_i | input | 1 | One-minute tick strobe |
| phase_64_i | input | 1 | 64 Hz square phase used to time the pulse release |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 0 preset, 1 control, 2 status |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Live count |
| flag_o | output | 1 | Sticky event flag |
| enable_o | output | 1 | Run bit readback |
| irq_pull_o | output | 1 | Open-drain pull-low enable for the interrupt pin |

## Verification
A write or a sampled tick changes count_o, flag_o and enable_o exactly one clock edge later, and irq_pull_o follows in the same cycle because it is decoded from registered state alone. The bench drives every input on the falling clock edge, advances a behavioural model on each rising edge, and compares all four outputs with that model at the next falling edge. Directed checks then sample at points reached by polling an output, or after waits long enough to cover the one-tick arming and stopping uncertainty. Pulse widths are measured by counting consecutive falling-edge samples.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        SRC_4K = 2'd0,
        SRC_64 = 2'd1,
        SRC_1S = 2'd2,
        SRC_1M = 2'd3
    } ivt_src_e;

    localparam logic [1:0] ADDR_PRESET = 2'd0;
    localparam logic [1:0] ADDR_CTRL   = 2'd1;
    localparam logic [1:0] ADDR_STAT   = 2'd2;

    localparam int CTL_RUN_BIT  = 3;
    localparam int CTL_MODE_BIT = 2;
    localparam int STA_FLAG_BIT = 1;
    localparam int STA_IE_BIT   = 0;

endpackage

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel
    import ivt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ivt_src_e src_i,
    input  logic     tick_4k_i,
    input  logic     tick_64_i,
    input  logic     tick_1s_i,
    input  logic     tick_1m_i,
    input  logic     phase_i,
    output logic     tick_o,
    output logic     phase_fall_o
);

    logic ph_d, ph_q;

    always_comb begin
        unique case (src_i)
            SRC_4K:  tick_o = tick_4k_i;
            SRC_64:  tick_o = tick_64_i;
            SRC_1S:  tick_o = tick_1s_i;
            default: tick_o = tick_1m_i;
        endcase
        ph_d         = phase_i;
        phase_fall_o = ph_q && !phase_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ph_d;
    end

endmodule

// File: rtl/ivt_flag.sv
module ivt_flag #(
    parameter int GUARD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_req_i,
    output logic flag_o
);

    localparam int GW = $clog2(GUARD_CYC + 1);

    typedef struct packed {
        logic          flag;
        logic [GW-1:0] guard;
    } flag_t;

    flag_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.guard != '0) s_d.guard = s_q.guard - GW'(1);
        if (set_i) begin
            s_d.flag  = 1'b1;
            s_d.guard = GW'(GUARD_CYC);
        end else if (clr_req_i && s_q.guard == '0) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o = s_q.flag;

    // R9: without a clear request the flag never drops
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !clr_req_i) |=> s_q.flag);

    // R9: a freshly set flag survives the next edge whatever is written
    p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |=> s_q.flag);

endmodule

// File: rtl/ivt_return.sv
module ivt_return #(
    parameter int RET_FAST_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic periodic_i,
    input  logic fast_i,
    input  logic phase_fall_i,
    output logic pulse_o
);

    localparam int RW = $clog2(RET_FAST_CYC + 1);

    typedef struct packed {
        logic          pulse;
        logic [RW-1:0] ret;
    } ret_t;

    ret_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_i) begin
            s_d.pulse = 1'b1;
            s_d.ret   = RW'(RET_FAST_CYC);
        end else if (!periodic_i) begin
            s_d.pulse = 1'b0;
        end else if (s_q.pulse) begin
            if (fast_i) begin
                if (s_q.ret <= RW'(1)) s_d.pulse = 1'b0;
                if (s_q.ret != '0)     s_d.ret   = s_q.ret - RW'(1);
            end else if (phase_fall_i) begin
                s_d.pulse = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = s_q.pulse;

    // R8: a slow-source pulse holds until the phase falls
    p_slow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pulse && periodic_i && !fast_i && !phase_fall_i) |=> s_q.pulse);

endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int GUARD_CYC    = 4,
    parameter int RET_FAST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_4k_i,
    input  logic             tick_64_i,
    input  logic             tick_1s_i,
    input  logic             tick_1m_i,
    input  logic             phase_64_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             enable_o,
    output logic             irq_pull_o
);

    typedef struct packed {
        logic [CNT_W-1:0] preset;
        logic [CNT_W-1:0] count;
        logic             en;
        logic             run;
        logic             nostop;
        logic             periodic;
        ivt_src_e         src;
        logic             ie;
    } core_t;

    core_t s_d, s_q;

    logic tick, phase_fall, ev, flag, pulse;
    logic wr_preset, wr_ctrl, wr_stat, clr_req;

    ivt_tick_sel u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (s_q.src),
        .tick_4k_i   (tick_4k_i),
        .tick_64_i   (tick_64_i),
        .tick_1s_i   (tick_1s_i),
        .tick_1m_i   (tick_1m_i),
        .phase_i     (phase_64_i),
        .tick_o      (tick),
        .phase_fall_o(phase_fall)
    );

    ivt_flag #(.GUARD_CYC(GUARD_CYC)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ev),
        .clr_req_i(clr_req),
        .flag_o   (flag)
    );

    ivt_return #(.RET_FAST_CYC(RET_FAST_CYC)) u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (ev && s_q.periodic),
        .periodic_i  (s_q.periodic),
        .fast_i      (s_q.src == SRC_4K),
        .phase_fall_i(phase_fall),
        .pulse_o     (pulse)
    );

    always_comb begin
        wr_preset = wr_en_i && (wr_addr_i == ADDR_PRESET);
        wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
        wr_stat   = wr_en_i && (wr_addr_i == ADDR_STAT);
        clr_req   = wr_stat && !wr_data_i[STA_FLAG_BIT];

        s_d = s_q;
        ev  = 1'b0;

        // tick handling on the registered state
        if (s_q.run && tick) begin
            if (s_q.count != '0) begin
                s_d.count = s_q.count - CNT_W'(1);
                ev        = (s_q.count == CNT_W'(1));
            end
            if (ev && s_q.periodic) s_d.count = s_q.preset;
            if (!s_q.en)            s_d.run   = 1'b0;
        end else if (s_q.en && !s_q.run && tick) begin
            s_d.run = 1'b1;
        end

        if (ev && !s_q.periodic && !s_q.nostop) begin
            s_d.en  = 1'b0;
            s_d.run = 1'b0;
        end

        // software writes take precedence
        if (wr_preset) begin
            s_d.preset = wr_data_i;
            s_d.count  = wr_data_i;
        end
        if (wr_ctrl) begin
            if (wr_data_i[CTL_RUN_BIT] && !s_q.en) s_d.nostop = flag;
            s_d.en       = wr_data_i[CTL_RUN_BIT];
            s_d.periodic = wr_data_i[CTL_MODE_BIT];
            s_d.src      = ivt_src_e'(wr_data_i[1:0]);
        end
        if (wr_stat) s_d.ie = wr_data_i[STA_IE_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.src <= SRC_4K;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o    = s_q.count;
    assign flag_o     = flag;
    assign enable_o   = s_q.en;
    assign irq_pull_o = s_q.ie && (s_q.periodic ? pulse : flag);

    // R3: an unarmed counter never moves without a preset write
    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !wr_preset) |=> $stable(s_q.count));

    // R5: a level zero event drops the run bit unless software rewrites it
    p_level_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !s_q.periodic && !s_q.nostop && !wr_ctrl) |=> !s_q.en);

    // R7: periodic zero event reloads the preset
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && s_q.periodic && !wr_preset) |=> (s_q.count == $past(s_q.preset)));

    // R10: a zero count never wraps or raises the flag
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == '0 && !wr_preset && !flag && !wr_en_i) |=> (s_q.count == '0 && !flag));

endmodule

// File: tb/ivt_core_bench.sv
module ivt_core_bench;

    localparam int GUARD = 4;
    localparam int RETF  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t4k = 0, t64 = 0, t1s = 0, t1m = 0, ph = 0;
    logic       wr_en = 0;
    logic [1:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] count;
    logic       flag, en, irq;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ivt_core #(.CNT_W(8), .GUARD_CYC(GUARD), .RET_FAST_CYC(RETF)) u_ivt_core (
        .clk(clk), .rst_n(rst_n),
        .tick_4k_i(t4k), .tick_64_i(t64), .tick_1s_i(t1s), .tick_1m_i(t1m),
        .phase_64_i(ph), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .count_o(count), .flag_o(flag), .enable_o(en), .irq_pull_o(irq)
    );

    // scaled tick generation: slow ticks sit on the phase rising edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        t4k <= (cyc % 4) == 0;
        t64 <= (cyc % 32) == 0;
        t1s <= (cyc % 128) == 0;
        t1m <= (cyc % 512) == 0;
        ph  <= (cyc % 32) < 16;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_pre, m_cnt, m_en, m_run, m_nos, m_per, m_src, m_ie;
    int m_flag, m_guard, m_pulse, m_ret, m_ph;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_en = 0; m_run = 0; m_nos = 0; m_per = 0;
            m_src = 0; m_ie = 0; m_flag = 0; m_guard = 0; m_pulse = 0; m_ret = 0; m_ph = 0;
        end else begin
            int tk, fall, ev, old_flag, old_guard, old_en, old_per;
            tk = (m_src == 0) ? t4k : (m_src == 1) ? t64 : (m_src == 2) ? t1s : t1m;
            fall = m_ph && !ph;
            ev = 0; old_flag = m_flag; old_guard = m_guard; old_en = m_en; old_per = m_per;
            if (m_run && tk) begin
                if (m_cnt > 0) begin m_cnt--; if (m_cnt == 0) ev = 1; end
                if (ev && m_per) m_cnt = m_pre;
                if (!m_en) m_run = 0;
            end else if (m_en && tk) m_run = 1;
            if (m_guard > 0) m_guard--;
            if (ev) begin
                m_flag = 1; m_guard = GUARD;
                if (!m_per && !m_nos) begin m_en = 0; m_run = 0; end
            end
            if (ev && old_per) begin m_pulse = 1; m_ret = RETF; end
            else if (!old_per) m_pulse = 0;
            else if (m_pulse) begin
                if (m_src == 0) begin
                    if (m_ret <= 1) m_pulse = 0;
                    if (m_ret > 0) m_ret--;
                end else if (fall) m_pulse = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_pre = wr_data; m_cnt = wr_data; end
                    2'd1: begin
                        if (wr_data[3] && !old_en) m_nos = old_flag;
                        m_en = wr_data[3]; m_per = wr_data[2]; m_src = wr_data[1:0];
                    end
                    2'd2: begin
                        m_ie = wr_data[0];
                        if (!wr_data[1] && !ev && old_guard == 0) m_flag = 0;
                    end
                    default: ;
                endcase
            end
            m_ph = ph;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 model count", count, m_cnt);
            chk("R9 model flag", flag, m_flag);
            chk("R5 model enable", en, m_en);
            chk("R11 model irq", irq, m_ie && (m_per ? m_pulse : m_flag));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input logic lvl, input int lim, input string tag);
        int k = 0;
        while (irq !== lvl && k < lim) begin @(negedge clk); k++; end
        if (k >= lim) chk(tag, irq, lvl);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset irq", irq, 0);
        chk("R2 reset count", count, 0);
        chk("R9 reset flag", flag, 0);
        chk("R5 reset enable", en, 0);

        wr(2, 8'h01);
        wr(0, 8'd5);
        chk("R2 preset loads count", count, 5);

        // level mode, 64 Hz source
        wr(1, 8'b1001);
        idle(20);
        chk("R3 first tick only arms", count, 5);
        idle(260);
        chk("R5 count at zero", count, 0);
        chk("R5 flag set", flag, 1);
        chk("R5 run cleared", en, 0);
        chk("R11 level irq", irq, 1);

        wr(2, 8'b11);
        chk("R9 write one keeps flag", flag, 1);
        wr(2, 8'b10);
        chk("R11 irq released by ie=0", irq, 0);
        chk("R11 flag kept with ie=0", flag, 1);
        wr(2, 8'b00);
        chk("R9 clear after guard", flag, 0);
        wr(2, 8'b11);
        chk("R9 write one ignored", flag, 0);

        // start while flag set keeps running
        wr(0, 8'd1); wr(1, 8'b1000); idle(20);
        chk("R5 fast level event", flag, 1);
        wr(0, 8'd2); wr(1, 8'b1000); idle(30);
        chk("R6 count zero", count, 0);
        chk("R6 run kept", en, 1);
        wr(1, 8'b0000); idle(10);

        // clear inside guard window
        wr(2, 8'b01); idle(10);
        chk("R9 cleared", flag, 0);
        wr(0, 8'd2); wr(1, 8'b1000);
        begin
            int k = 0;
            while (!flag && k < 60) begin @(negedge clk); k++; end
        end
        wr(2, 8'b01);
        chk("R9 clear blocked in guard", flag, 1);
        idle(10); wr(2, 8'b01);
        chk("R9 clear after window", flag, 0);

        // stop takes at most one more tick
        begin
            int c0, c1;
            wr(0, 8'd200); wr(1, 8'b1000); idle(40);
            wr(1, 8'b0000);
            c0 = count; idle(12); c1 = count; idle(40);
            chk("R4 frozen after stop", count, c1);
            chk("R4 at most one extra", (c0 - c1) <= 1, 1);
        end

        // source selection
        wr(0, 8'd200); wr(1, 8'b1010); idle(400);
        chk("R1 one-second source", (count >= 196 && count <= 199), 1);
        wr(1, 8'b0010); idle(200);
        wr(0, 8'd200); wr(1, 8'b1011); idle(1200);
        chk("R1 minute source", (count >= 198 && count <= 199), 1);
        wr(1, 8'b0011); idle(1100);

        // periodic, fast source
        wr(2, 8'b01); idle(10);
        wr(0, 8'd3); wr(1, 8'b1100);
        wait_irq(1'b0, 40, "R8 idle before pulse");
        wait_irq(1'b1, 80, "R7 periodic event");
        chk("R7 reload on event", count, 3);
        begin
            int w = 0;
            while (irq && w < 100) begin @(negedge clk); w++; end
            chk("R8 fast pulse width", w, RETF);
        end
        chk("R11 periodic irq released, flag held", flag, 1);
        wait_irq(1'b1, 80, "R7 second event");
        chk("R7 repeat reload", count, 3);
        wr(1, 8'b0000); idle(20);

        // periodic, 64 Hz source
        wr(0, 8'd2); wr(1, 8'b1101);
        wait_irq(1'b0, 40, "R8 idle before slow pulse");
        wait_irq(1'b1, 200, "R8 slow event");
        begin
            int w = 0;
            while (irq && w < 100) begin @(negedge clk); w++; end
            chk("R8 slow pulse width", w, 16);
        end
        wr(1, 8'b0001); idle(80);

        // zero preset produces nothing
        wr(2, 8'b01); idle(10);
        wr(0, 8'd0); wr(1, 8'b1100);
        begin
            int hits = 0;
            repeat (120) begin @(negedge clk); if (irq) hits++; end
            chk("R10 no pulses", hits, 0);
        end
        chk("R10 flag stays clear", flag, 0);
        chk("R10 count stays zero", count, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule